// File: doc/BRIEF.md
# Hot-Plug Interrupt Locator and Aggregator

This block collects the per-slot event flags of a hot-plug controller and the completion flag of its command engine, and turns them into one interrupt request. Each slot has a byte of latched event flags and a byte of per-event masks. Hardware sets the event flags with single-cycle pulses, and software clears them by writing ones. A global control register holds the interrupt masks and two sticky detection flags.

A read-only locator word shows which sources are pending. Bit 0 stands for a completed command, and bit i+1 stands for slot i. When the global interrupt mask is clear and any locator bit is set, the combined level is high. The level drives a legacy interrupt line while message signalling is off. While message signalling is on, the block raises a one-cycle message request each time the level changes instead.

Software uses a single register port: a write strobe with an address and a 32-bit data word, and a read address with a combinational data output.

Top module: `hp_irq_agg`

## Requirements
- R1: After reset every event latch is 0, every slot mask byte is 0x7F, the control register reads 0x0000000F, and irq_o, msi_req_o and locator_o are 0.
- R2: A pulse on slot s event input bit b (b in 0..4, input index s*5+b) sets latch bit b of slot s on the next clock edge. The bit stays set until software clears it.
- R3: Slot s is read and written at address 2+s. Bits 4:0 hold the latch, and writing 1 to a latch bit clears it. Bits 7:5 always read 0.
- R4: If a hardware set and a software clear hit the same latch bit in the same cycle, the bit ends up set.
- R5: Bits 14:8 of a slot register are the mask byte, written directly from the data. Bit 15 and bits 31:16 read 0.
- R6: Locator bit s+1 is 1 exactly when slot s has a latched event whose mask bit (bit 8+b of the slot register) is 0. The mask bits at positions 13 and 14 never mask an event.
- R7: Locator bit 0 is 1 exactly when control bit 16 (command detected) is 1 and control bit 2 (command interrupt mask) is 0.
- R8: Control register, address 0. Bits 3:0 are written directly. Bits 16 and 17 are set by cmd_done_i and arb_err_i pulses and cleared by writing 1. A set wins over a same-cycle clear. All other bits read 0.
- R9: The level is 1 when control bit 0 is 0 and the locator is non-zero. irq_o equals the level while msi_en_i is 0, and irq_o is 0 while msi_en_i is 1.
- R10: The block records the level in every cycle, and the recorded value resets to 0. msi_req_o is 1 in a cycle exactly when msi_en_i is 1 and the current level differs from the level recorded at the previous edge.
- R11: Address 1 reads the locator zero-extended, and writes to address 1 change no state.
- R12: Addresses above 1+NUM_SLOTS read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read register address |
| rd_data_o | output | 32 | Read data, combinational |
| evt_set_i | input | NUM_SLOTS*5 | Per-slot event set pulses |
| cmd_done_i | input | 1 | Command completed pulse |
| arb_err_i | input | 1 | Arbiter error pulse |
| msi_en_i | input | 1 | Message signalling enabled |
| locator_o | output | NUM_SLOTS+1 | Pending source locator |
| irq_o | output | 1 | Legacy level interrupt |
| msi_req_o | output | 1 | Message request pulse on a level change |

## Verification
The bench builds the block with NUM_SLOTS=5, so the address field is 3 bits wide. That leaves address 7 as a spare location, which brings the unmapped-address behaviour within reach. With five slots, the random writes and event pulses also cover every slot register, every locator bit and the top slot edge many times. The random phases toggle msi_en_i, which exercises both the legacy path and the message path. They also exercise level transitions in both directions.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
  localparam int unsigned EVT_W      = 5;   // latched event kinds per slot
  localparam int unsigned DIS_W      = 7;   // mask byte width per slot
  localparam int unsigned DIS_LSB    = 8;   // mask field position in slot word
  localparam int unsigned GDIS_W     = 4;   // writable global mask bits
  localparam int unsigned B_INT_DIS  = 0;
  localparam int unsigned B_CMD_DIS  = 2;
  localparam int unsigned B_CMD_DET  = 16;
  localparam int unsigned B_ARB_DET  = 17;
  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_LOC      = 1;
  localparam int unsigned A_SLOT0    = 2;
endpackage

// File: rtl/hp_slot_evt.sv
module hp_slot_evt
  import hp_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] set_i,
  input  logic             wr_i,
  input  logic [EVT_W-1:0] clr_i,
  input  logic [DIS_W-1:0] dis_i,
  output logic [EVT_W-1:0] latch_o,
  output logic [DIS_W-1:0] dis_o,
  output logic             pend_o
);
  logic [EVT_W-1:0] latch_q;
  logic [DIS_W-1:0] dis_q;
  logic [EVT_W-1:0] clr_m;

  assign clr_m = wr_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dis_q   <= '1;
    end else begin
      latch_q <= (latch_q & ~clr_m) | set_i;  // set wins
      if (wr_i) dis_q <= dis_i;
    end
  end

  assign latch_o = latch_q;
  assign dis_o   = dis_q;
  assign pend_o  = |(latch_q & ~dis_q[EVT_W-1:0]);
endmodule

// File: rtl/hp_irq_ctrl.sv
module hp_irq_ctrl
  import hp_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [GDIS_W-1:0] dis_i,
  input  logic              clr_cmd_i,
  input  logic              clr_arb_i,
  input  logic              cmd_done_i,
  input  logic              arb_err_i,
  output logic [31:0]       ctrl_o
);
  logic [GDIS_W-1:0] dis_q;
  logic              cmd_q, arb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q <= '1;
      cmd_q <= 1'b0;
      arb_q <= 1'b0;
    end else begin
      if (wr_i) dis_q <= dis_i;
      cmd_q <= (cmd_q & ~(wr_i & clr_cmd_i)) | cmd_done_i;
      arb_q <= (arb_q & ~(wr_i & clr_arb_i)) | arb_err_i;
    end
  end

  always_comb begin
    ctrl_o                  = '0;
    ctrl_o[GDIS_W-1:0]      = dis_q;
    ctrl_o[B_CMD_DET]       = cmd_q;
    ctrl_o[B_ARB_DET]       = arb_q;
  end
endmodule

// File: rtl/hp_msi_notify.sv
module hp_msi_notify (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic msi_en_i,
  output logic irq_o,
  output logic msi_req_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= level_i;
  end

  assign msi_req_o = msi_en_i & (level_i ^ last_q);
  assign irq_o     = level_i & ~msi_en_i;
endmodule

// File: rtl/hp_irq_agg.sv
module hp_irq_agg
  import hp_irq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned ADDR_W    = $clog2(NUM_SLOTS + 3)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [31:0]                wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [31:0]                rd_data_o,
  input  logic [NUM_SLOTS*EVT_W-1:0] evt_set_i,
  input  logic                       cmd_done_i,
  input  logic                       arb_err_i,
  input  logic                       msi_en_i,
  output logic [NUM_SLOTS:0]         locator_o,
  output logic                       irq_o,
  output logic                       msi_req_o
);
  localparam int unsigned LOC_W = NUM_SLOTS + 1;

  logic [NUM_SLOTS*EVT_W-1:0] latch_flat;
  logic [EVT_W-1:0]           latch [NUM_SLOTS];
  logic [DIS_W-1:0]           dis   [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]       pend;
  logic [31:0]                ctrl_q;
  logic [LOC_W-1:0]           loc;
  logic                       level;
  logic                       unused_wdata;

  assign unused_wdata = ^{wr_data_i[31:18], wr_data_i[15], wr_data_i[7:5]};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic wr_s;
    assign wr_s = wr_en_i && (wr_addr_i == ADDR_W'(A_SLOT0 + s));
    hp_slot_evt u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_set_i[s*EVT_W +: EVT_W]),
      .wr_i   (wr_s),
      .clr_i  (wr_data_i[EVT_W-1:0]),
      .dis_i  (wr_data_i[DIS_LSB +: DIS_W]),
      .latch_o(latch[s]),
      .dis_o  (dis[s]),
      .pend_o (pend[s])
    );
    assign latch_flat[s*EVT_W +: EVT_W] = latch[s];
  end

  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));

  hp_irq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .dis_i     (wr_data_i[GDIS_W-1:0]),
    .clr_cmd_i (wr_data_i[B_CMD_DET]),
    .clr_arb_i (wr_data_i[B_ARB_DET]),
    .cmd_done_i(cmd_done_i),
    .arb_err_i (arb_err_i),
    .ctrl_o    (ctrl_q)
  );

  assign loc[0]         = ctrl_q[B_CMD_DET] & ~ctrl_q[B_CMD_DIS];
  assign loc[LOC_W-1:1] = pend;
  assign level          = ~ctrl_q[B_INT_DIS] & (|loc);
  assign locator_o      = loc;

  hp_msi_notify u_msi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .msi_en_i (msi_en_i),
    .irq_o    (irq_o),
    .msi_req_o(msi_req_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(A_CTRL)) rd_data_o = ctrl_q;
    if (rd_addr_i == ADDR_W'(A_LOC))  rd_data_o = 32'(loc);
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (rd_addr_i == ADDR_W'(A_SLOT0 + s))
        rd_data_o = {17'b0, dis[s], 3'b0, latch[s]};
    end
  end
endmodule

// File: rtl/hp_irq_agg_chk.sv
module hp_irq_agg_chk
  import hp_irq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_SLOTS*EVT_W-1:0] evt_set_i,
  input logic [NUM_SLOTS*EVT_W-1:0] latch_flat,
  input logic                       cmd_done_i,
  input logic [31:0]                ctrl_q,
  input logic                       msi_en_i,
  input logic                       msi_req_o,
  input logic                       irq_o,
  input logic [NUM_SLOTS:0]         locator_o
);
  for (genvar k = 0; k < NUM_SLOTS*EVT_W; k++) begin : g_bit
    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_set_i[k] |=> latch_flat[k]);
  end

  assert_cmd_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> ctrl_q[B_CMD_DET]);

  assert_loc_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locator_o[0] |-> (ctrl_q[B_CMD_DET] && !ctrl_q[B_CMD_DIS]));

  assert_irq_legacy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!msi_en_i && (|locator_o) && !ctrl_q[B_INT_DIS]));

  assert_msi_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_req_o |-> msi_en_i);

  assert_excl_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && msi_req_o));
endmodule

bind hp_irq_agg hp_irq_agg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_set_i (evt_set_i),
  .latch_flat(latch_flat),
  .cmd_done_i(cmd_done_i),
  .ctrl_q    (ctrl_q),
  .msi_en_i  (msi_en_i),
  .msi_req_o (msi_req_o),
  .irq_o     (irq_o),
  .locator_o (locator_o)
);

// File: tb/hp_irq_agg_test.sv
`timescale 1ns/1ps
module hp_irq_agg_test;
  localparam int NS = 5;
  localparam int AW = 3;
  localparam int EW = 5;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [31:0]    wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [31:0]    rd_data;
  logic [NS*EW-1:0] evt = '0;
  logic           cmd = 1'b0;
  logic           arb = 1'b0;
  logic           msi_en = 1'b0;
  logic [NS:0]    loc;
  logic           irq, msi;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  hp_irq_agg #(.NUM_SLOTS(NS), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_set_i(evt), .cmd_done_i(cmd), .arb_err_i(arb), .msi_en_i(msi_en),
    .locator_o(loc), .irq_o(irq), .msi_req_o(msi)
  );

  // reference model
  logic [4:0]  m_latch [NS];
  logic [6:0]  m_dis   [NS];
  logic [3:0]  m_gdis;
  logic        m_cmd, m_arb, m_last;

  function automatic logic [NS:0] f_loc();
    logic [NS:0] l;
    l[0] = m_cmd & ~m_gdis[2];
    for (int s = 0; s < NS; s++) l[s+1] = |(m_latch[s] & ~m_dis[s][4:0]);
    return l;
  endfunction

  function automatic logic f_level();
    return ~m_gdis[0] & (|f_loc());
  endfunction

  function automatic logic [31:0] f_read(logic [AW-1:0] a);
    if (a == 0) return {14'b0, m_arb, m_cmd, 12'b0, m_gdis};
    if (a == 1) return 32'(f_loc());
    if (a >= 2 && a < 2 + NS) return {17'b0, m_dis[a-2], 3'b0, m_latch[a-2]};
    return 32'h0;
  endfunction

  function automatic string f_rtag(logic [AW-1:0] a);
    if (a == 0) return "R8";
    if (a == 1) return "R11";
    if (a >= 2 && a < 2 + NS) return "R3";
    return "R12";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin m_latch[s] = '0; m_dis[s] = 7'h7F; end
    m_gdis = 4'hF; m_cmd = 0; m_arb = 0; m_last = 0;
  endtask

  task automatic idle();
    wr_en = 0; wr_data = '0; wr_addr = '0; evt = '0; cmd = 0; arb = 0;
  endtask

  // one clock: update model with current inputs, then check outputs
  task automatic step();
    logic lv;
    lv = f_level();
    @(posedge clk);
    if (wr_en && wr_addr == 0) m_gdis = wr_data[3:0];
    m_cmd = (m_cmd & ~(wr_en && wr_addr == 0 && wr_data[16])) | cmd;
    m_arb = (m_arb & ~(wr_en && wr_addr == 0 && wr_data[17])) | arb;
    for (int s = 0; s < NS; s++) begin
      logic [4:0] c;
      c = (wr_en && wr_addr == AW'(2 + s)) ? wr_data[4:0] : 5'b0;
      m_latch[s] = (m_latch[s] & ~c) | evt[s*EW +: EW];
      if (wr_en && wr_addr == AW'(2 + s)) m_dis[s] = wr_data[14:8];
    end
    m_last = lv;
    #1;
    chk("R6 locator", 32'(loc), 32'(f_loc()));
    chk("R9 irq", 32'(irq), 32'(f_level() & ~msi_en));
    chk("R10 msi", 32'(msi), 32'(msi_en & (f_level() ^ m_last)));
    chk({f_rtag(rd_addr), " read"}, rd_data, f_read(rd_addr));
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    model_reset();
    #7;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd_addr = AW'(a); #1;
      chk("R1 reset read", rd_data, f_read(AW'(a)));
    end
    chk("R1 reset outputs", {30'b0, irq, msi}, 32'h0);
    chk("R1 reset locator", 32'(loc), 32'h0);
    @(posedge clk); #1; rst_ni = 1;

    // R2: event on slot 3 bit 2 stays latched, masked from locator
    rd_addr = 5; evt[3*EW + 2] = 1; step(); idle();
    step(); step();
    chk("R2 sticky latch", rd_data & 32'h1F, 32'h4);
    // R5: mask write, bit 15 ignored
    wr(5, 32'h0000_FF00); step(); idle();
    chk("R5 mask field", rd_data & 32'hFF00, 32'h7F00);
    // R6: unmask button event -> locator bit 4
    wr(5, 32'h0000_6000); step(); idle();
    chk("R6 slot3 pending", 32'(loc), 32'h10);
    // R9: global mask still set -> no irq; clear it
    chk("R9 masked", 32'(irq), 32'h0);
    wr(0, 32'h0); rd_addr = 0; step(); idle();
    chk("R9 level irq", 32'(irq), 32'h1);
    // R4: set and clear same bit same cycle
    rd_addr = 5; wr(5, 32'h0000_6004); evt[3*EW + 2] = 1; step(); idle();
    chk("R4 set wins", rd_data & 32'h1F, 32'h4);
    // R3: clear it
    wr(5, 32'h0000_6004); step(); idle();
    chk("R3 w1c", rd_data & 32'hFF, 32'h0);
    // R7: command detected with cmd mask clear
    cmd = 1; step(); idle();
    chk("R7 loc bit0", 32'(loc), 32'h1);
    wr(0, 32'h4); step(); idle();
    chk("R7 masked cmd", 32'(loc), 32'h0);
    // R8: w1c of detected flag, set wins
    rd_addr = 0; wr(0, 32'h0001_0000); cmd = 1; arb = 1; step(); idle();
    chk("R8 set wins", rd_data, 32'h0003_0000);
    wr(0, 32'h0003_0000); step(); idle();
    chk("R8 cleared", rd_data, 32'h0);
    // R10: message mode edges
    msi_en = 1; cmd = 1; step(); idle();
    chk("R10 rise pulse", 32'(msi), 32'h1);
    step();
    chk("R10 one cycle", 32'(msi), 32'h0);
    wr(0, 32'h0001_0000); step(); idle();
    chk("R10 fall pulse", 32'(msi), 32'h1);
    msi_en = 0;
    // R11/R12: ignored writes
    wr(1, 32'hFFFF_FFFF); rd_addr = 1; step(); idle();
    wr(7, 32'hFFFF_FFFF); rd_addr = 7; step(); idle();
    chk("R12 spare read", rd_data, 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      wr_en = (r < 4);
      wr_addr = AW'($urandom_range(0, 7));
      wr_data = $urandom();
      if (wr_addr == 0 && $urandom_range(0, 3) != 0) wr_data[0] = 0;
      evt = '0;
      if ($urandom_range(0, 3) == 0) evt[$urandom_range(0, NS*EW-1)] = 1;
      cmd = ($urandom_range(0, 7) == 0);
      arb = ($urandom_range(0, 7) == 0);
      rd_addr = AW'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) msi_en = ~msi_en;
      step();
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule